// File: doc/BRIEF.md
# Register-Write to Stream Packet Transmitter

This block turns a processor's plain register writes into beats on a streaming master port. Software first writes the packet length, then for every beat writes a metadata word (byte strobes, end-of-packet flag, source and destination port fields) followed by a data word. Each data write builds one complete beat from the data word and the latest metadata and length values. The beat is queued in a beat FIFO, and the FIFO drains on a valid/ready stream carrying data, byte-keep, last and a user sideband.

Data words arrive with the first packet byte in the most significant byte lane. The block reverses the byte order so that the first byte leaves on the lowest lane of the stream. Length and metadata words are taken as written, with no reordering. The default FIFO holds 1024 beats of 32 bits, which is 4 KB, or roughly three full-size frames.

Top module: `mmio_stream_tx`

## Requirements
- R1: After reset `m_tvalid_o` and `overflow_o` are 0.
- R2: A write to offset 0x00 (data) pushes one beat, and `m_tvalid_o` rises on the clock edge that samples the write when the FIFO was empty. Byte lane k of `m_tdata_o` (bits 8k+7:8k) equals byte lane N-1-k of the written word, where N = DATA_W/8.
- R3: A write to offset 0x08 stores the metadata word. Each beat then carries `m_tkeep_o` = metadata bits N-1:0, `m_tlast_o` = metadata bit 15, `m_tuser_o[23:16]` = metadata bits 23:16 (source port, one-hot) and `m_tuser_o[31:24]` = metadata bits 31:24 (destination port, one-hot).
- R4: A write to offset 0x10 stores bits 15:0 as the packet length. Every later beat carries it on `m_tuser_o[15:0]` until the next length write.
- R5: Metadata and length stay in force across data writes, so several data writes after a single metadata write all carry that same metadata.
- R6: Beats leave in write order. While `m_tvalid_o` is 1 and `m_tready_i` is 0, the block keeps `m_tvalid_o` at 1 and holds data, keep, last and user stable.
- R7: A data write that arrives while the FIFO holds FIFO_DEPTH beats is dropped, even if a beat leaves in the same cycle. The drop sets `overflow_o`, which stays at 1 until reset.
- R8: A write to any other offset changes nothing: it pushes no beat and alters neither the stored metadata nor the stored length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Byte offset of the write |
| wr_data_i | input | DATA_W | Write data |
| m_tvalid_o | output | 1 | Stream beat valid |
| m_tready_i | input | 1 | Stream sink ready |
| m_tdata_o | output | DATA_W | Beat data, first byte on lane 0 |
| m_tkeep_o | output | DATA_W/8 | Byte keep |
| m_tlast_o | output | 1 | Last beat of packet |
| m_tuser_o | output | 32 | {dest port, source port, length} |
| overflow_o | output | 1 | Sticky FIFO overflow flag |

## Verification
There is one register stage between a data write and the stream. A beat written into an empty FIFO is therefore visible from the edge that samples the write, a pop takes effect at the edge where valid and ready are both high, and the overflow flag rises at the edge that samples the dropped write. The bench drives inputs and compares outputs on falling edges. Its queue model is updated on the same rising edge as the design, so each comparison sees the state one edge after the stimulus. The phases cover back-to-back writes, metadata reuse, unmapped offsets, a long stall and a fill past capacity with a simultaneous pop.

// File: rtl/mmio_stream_tx_pkg.sv
package mmio_stream_tx_pkg;
  localparam int unsigned OFF_DATA  = 'h00;
  localparam int unsigned OFF_META  = 'h08;
  localparam int unsigned OFF_LEN   = 'h10;
  localparam int unsigned LAST_BIT  = 15;
  localparam int unsigned SPORT_LSB = 16;
  localparam int unsigned DPORT_LSB = 24;
  localparam int unsigned PORT_W    = 8;
  localparam int unsigned LEN_W     = 16;
  localparam int unsigned USER_W    = 2 * PORT_W + LEN_W;

  typedef enum logic [1:0] {SEL_NONE, SEL_DATA, SEL_META, SEL_LEN} reg_sel_e;
endpackage

// File: rtl/tx_reg_decode.sv
module tx_reg_decode
  import mmio_stream_tx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned ENTRY_W = USER_W + 1 + DATA_W / 8 + DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               push_o,
  output logic [ENTRY_W-1:0] entry_o
);
  localparam int unsigned STRB_W = DATA_W / 8;

  reg_sel_e         sel;
  logic [31:0]      meta_q;
  logic [LEN_W-1:0] len_q;
  logic [DATA_W-1:0] swapped;

  always_comb begin
    sel = SEL_NONE;
    if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(OFF_DATA))      sel = SEL_DATA;
      else if (wr_addr_i == ADDR_W'(OFF_META)) sel = SEL_META;
      else if (wr_addr_i == ADDR_W'(OFF_LEN))  sel = SEL_LEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      len_q  <= '0;
    end else begin
      if (sel == SEL_META) meta_q <= wr_data_i[31:0];
      if (sel == SEL_LEN)  len_q  <= wr_data_i[LEN_W-1:0];
    end
  end

  // first packet byte arrives in the top lane; move it to lane 0
  for (genvar g = 0; g < STRB_W; g++) begin : g_swap
    assign swapped[8*g +: 8] = wr_data_i[DATA_W-8*(g+1) +: 8];
  end

  assign push_o  = (sel == SEL_DATA);
  assign entry_o = {meta_q[DPORT_LSB +: PORT_W], meta_q[SPORT_LSB +: PORT_W], len_q,
                    meta_q[LAST_BIT], meta_q[STRB_W-1:0], swapped};
endmodule

// File: rtl/tx_beat_fifo.sv
module tx_beat_fifo #(
  parameter int unsigned WIDTH = 69,
  parameter int unsigned DEPTH = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push)
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mmio_stream_tx.sv
module mmio_stream_tx
  import mmio_stream_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned FIFO_DEPTH = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic                m_tvalid_o,
  input  logic                m_tready_i,
  output logic [DATA_W-1:0]   m_tdata_o,
  output logic [DATA_W/8-1:0] m_tkeep_o,
  output logic                m_tlast_o,
  output logic [USER_W-1:0]   m_tuser_o,
  output logic                overflow_o
);
  localparam int unsigned STRB_W  = DATA_W / 8;
  localparam int unsigned ENTRY_W = USER_W + 1 + STRB_W + DATA_W;

  logic               push, fifo_empty, fifo_full, pop;
  logic [ENTRY_W-1:0] entry_in, entry_out;
  logic               ovf_q;

  tx_reg_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) dec_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .push_o(push), .entry_o(entry_in)
  );

  tx_beat_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(entry_in), .pop_i(pop),
    .rdata_o(entry_out), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  assign pop        = m_tvalid_o && m_tready_i;
  assign m_tvalid_o = !fifo_empty;
  assign m_tdata_o  = entry_out[DATA_W-1:0];
  assign m_tkeep_o  = entry_out[DATA_W +: STRB_W];
  assign m_tlast_o  = entry_out[DATA_W + STRB_W];
  assign m_tuser_o  = entry_out[ENTRY_W-1 -: USER_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (push && fifo_full) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;
endmodule

// File: rtl/mmio_stream_tx_chk.sv
module mmio_stream_tx_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                push,
  input logic                fifo_full,
  input logic                m_tvalid_o,
  input logic                m_tready_i,
  input logic [DATA_W-1:0]   m_tdata_o,
  input logic [DATA_W/8-1:0] m_tkeep_o,
  input logic                m_tlast_o,
  input logic [31:0]         m_tuser_o,
  input logic                overflow_o
);
  p_push_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !fifo_full) |=> m_tvalid_o)
    else $error("push without valid");

  p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o) && $stable(m_tkeep_o)
                                     && $stable(m_tlast_o) && $stable(m_tuser_o)))
    else $error("stream changed under backpressure");

  p_drop_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && fifo_full) |=> overflow_o)
    else $error("drop did not flag overflow");

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o)
    else $error("overflow flag cleared");

  p_full_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full && !m_tready_i) |=> fifo_full)
    else $error("full fifo changed without pop");
endmodule

bind mmio_stream_tx mmio_stream_tx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .push(push), .fifo_full(fifo_full),
  .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i), .m_tdata_o(m_tdata_o),
  .m_tkeep_o(m_tkeep_o), .m_tlast_o(m_tlast_o), .m_tuser_o(m_tuser_o),
  .overflow_o(overflow_o)
);

// File: tb/mmio_stream_tx_tb_top.sv
module mmio_stream_tx_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1024;
  localparam int NB     = DATA_W / 8;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic [NB-1:0]     keep;
    logic              last;
    logic [31:0]       user;
  } beat_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, rdy = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic m_tvalid, m_tlast, ovf;
  logic [DATA_W-1:0] m_tdata;
  logic [NB-1:0] m_tkeep;
  logic [31:0] m_tuser;

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1";
  bit run_cmp = 1'b0;

  beat_t q[$];
  logic [31:0] m_meta = '0;
  logic [15:0] m_len = '0;
  bit m_ovf = 1'b0;

  always #4 clk = ~clk;

  mmio_stream_tx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(wdata),
    .m_tvalid_o(m_tvalid), .m_tready_i(rdy), .m_tdata_o(m_tdata), .m_tkeep_o(m_tkeep),
    .m_tlast_o(m_tlast), .m_tuser_o(m_tuser), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s phase=%s actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_ni) begin
      q.delete(); m_meta = '0; m_len = '0; m_ovf = 1'b0;
    end else begin
      bit full;
      full = (q.size() == DEPTH);
      if (rdy && q.size() != 0) void'(q.pop_front());
      if (wr_en && addr == 5'h00) begin
        if (full) m_ovf = 1'b1;
        else begin
          beat_t b;
          for (int k = 0; k < NB; k++) b.data[8*k +: 8] = wdata[8*(NB-1-k) +: 8];
          b.keep = m_meta[NB-1:0];
          b.last = m_meta[15];
          b.user = {m_meta[31:16], m_len};
          q.push_back(b);
        end
      end else if (wr_en && addr == 5'h08) m_meta = wdata;
      else if (wr_en && addr == 5'h10) m_len = wdata[15:0];
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      chk(m_tvalid == (q.size() != 0), "R6 valid", 64'(m_tvalid), 64'(q.size() != 0));
      chk(ovf == m_ovf, "R7 overflow", 64'(ovf), 64'(m_ovf));
      if (q.size() != 0 && m_tvalid) begin
        chk(m_tdata == q[0].data, "R2 data", 64'(m_tdata), 64'(q[0].data));
        chk(m_tkeep == q[0].keep && m_tlast == q[0].last, "R3 keep/last",
            64'({m_tkeep, m_tlast}), 64'({q[0].keep, q[0].last}));
        chk(m_tuser[31:16] == q[0].user[31:16], "R3 ports", 64'(m_tuser[31:16]), 64'(q[0].user[31:16]));
        chk(m_tuser[15:0] == q[0].user[15:0], "R4 length", 64'(m_tuser[15:0]), 64'(q[0].user[15:0]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      failures++;
      $display("FAIL watchdog phase=%s actual=%0d expected=<100000", phase, cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R1 valid", 64'(m_tvalid), 64'(0));
    chk(ovf == 1'b0, "R1 overflow", 64'(ovf), 64'(0));
    run_cmp = 1'b1;

    // R2, R3, R4: 10-byte packet, CPU0 (bit 1) to MAC0 (bit 0)
    phase = "R2"; rdy = 1'b1;
    wr(5'h10, 32'd10);
    wr(5'h08, 32'h0102_000F); wr(5'h00, 32'h0011_2233);
    wr(5'h08, 32'h0102_000F); wr(5'h00, 32'h4455_6677);
    wr(5'h08, 32'h0102_8003); wr(5'h00, 32'h8899_AABB);
    idle(3);

    // R5: one metadata write, several data writes, ready toggling
    phase = "R5";
    wr(5'h10, 32'hABCD_0040);
    wr(5'h08, 32'h4080_000F);
    for (int i = 0; i < 4; i++) begin
      rdy = i[0];
      wr(5'h00, 32'hC0DE_0000 + 32'(i));
    end
    rdy = 1'b1; idle(6);

    // R8: unmapped offsets must not push or alter stored state
    phase = "R8";
    wr(5'h04, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF); wr(5'h18, 32'hFFFF_FFFF);
    idle(2);
    chk(m_tvalid == 1'b0, "R8 no beat", 64'(m_tvalid), 64'(0));
    wr(5'h00, 32'h0102_0304);
    idle(2);

    // R6: stall with several beats queued
    phase = "R6"; rdy = 1'b0;
    wr(5'h08, 32'h2010_8001);
    for (int i = 0; i < 5; i++) wr(5'h00, 32'h1000_0000 * 32'(i + 1));
    idle(6);
    rdy = 1'b1; idle(8);

    // R7: fill past capacity, one drop with a simultaneous pop
    phase = "R7"; rdy = 1'b0;
    wr(5'h08, 32'h0804_000F);
    for (int i = 0; i < DEPTH + 2; i++) wr(5'h00, 32'(i));
    rdy = 1'b1;
    wr(5'h00, 32'hDEAD_BEEF);
    rdy = 1'b0;
    idle(2);
    chk(ovf == 1'b1, "R7 sticky", 64'(ovf), 64'(1));
    rdy = 1'b1;
    idle(DEPTH + 4);
    chk(ovf == 1'b1 && m_tvalid == 1'b0, "R7 after drain", 64'({ovf, m_tvalid}), 64'(2'b10));

    run_cmp = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule